// File: doc/BRIEF.md
# Global Interrupt Enable Controller

This block holds the master interrupt enable of a small accumulator-based core and makes the control decisions around interrupt entry and wake-up from sleep. It takes a pending flag and an enable for each interrupt source. It also takes decoded one-cycle strobes for the enable-interrupts, disable-interrupts and return-from-interrupt instructions, a sleep-state level and an instruction-boundary marker. From these it produces the master enable level, an interrupt-taken request that carries the vector address, and a wake-up request with a flag that says whether to branch or to resume.

The master enable has no data-write path. Only the three instruction strobes and interrupt entry itself can change it. Entry clears the flag so that a running handler is not interrupted again; the return strobe sets it back. When the core is asleep, any enabled pending source wakes it. The state of the master enable at that moment decides whether execution then branches to the vector or continues with the instruction after the sleep instruction. The program counter, the stack and the decoder stay outside this block.

Top module: `irq_gate_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the master enable `gie` is 0, and `take_irq`, `wake_req` and `wake_branch` are 0 as long as no source is both pending and enabled.
- R2: With no interrupt taken and no disable strobe, an enable strobe or a return strobe sets `gie` to 1 at the next clock edge.
- R3: A disable strobe clears `gie` at the next clock edge, and it wins over an enable or return strobe in the same cycle.
- R4: `take_irq` is 1 in a cycle exactly when `gie` is 1, at least one source has both its pending bit and its enable bit set, `insn_end` is 1 and `sleeping` is 0.
- R5: In a cycle with `take_irq` = 1, `gie` is 0 after the next clock edge, even if an enable or return strobe is present in that cycle.
- R6: `take_vec` equals 0x001 while `take_irq` is 1 and 0 otherwise.
- R7: `wake_req` is 1 exactly when `sleeping` is 1 and at least one source is both pending and enabled, whatever the value of `gie`.
- R8: `wake_branch` is 1 exactly when `wake_req` is 1 and `gie` is 1. The value 0 means resume at the instruction after the sleep instruction.
- R9: With no strobe and no interrupt taken, `gie` keeps its value across a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | NUM_SRC | Per-source pending flags |
| src_mask | input | NUM_SRC | Per-source enables, 1 = allowed |
| op_eni | input | 1 | Enable-interrupts instruction strobe |
| op_disi | input | 1 | Disable-interrupts instruction strobe |
| op_reti | input | 1 | Return-from-interrupt instruction strobe |
| sleeping | input | 1 | Core is in sleep state |
| insn_end | input | 1 | Current cycle is an instruction boundary |
| gie | output | 1 | Master interrupt enable |
| take_irq | output | 1 | Interrupt entry request |
| take_vec | output | VEC_W | Vector address during entry, else 0 |
| wake_req | output | 1 | Leave sleep |
| wake_branch | output | 1 | 1 = branch to vector after waking, 0 = resume |

## Verification
All combinations of pending and enable bits over three sources are swept against both master enable states, both boundary values and both sleep values. This separates a source that is pending but masked from one that is enabled but idle, and it separates entry from wake-up. A second sweep applies every combination of the three strobes, with and without a simultaneous entry and from both starting values of the flag. This pins down the order of precedence: entry first, then disable, then enable or return, then hold. Sleeping cases with the flag at 0 and at 1 show that the wake request does not depend on the flag and that the branch decision does.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    typedef struct packed {
        logic gie;
    } gate_state_t;

    localparam gate_state_t GATE_RESET = '{gie: 1'b0};
endpackage

// File: rtl/irq_src_any.sv
module irq_src_any #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_mask,
    output logic               any_live
);
    logic [NUM_SRC-1:0] live;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign live[i] = src_pend[i] & src_mask[i];
    end

    assign any_live = |live;
endmodule

// File: rtl/gie_flag.sv
module gie_flag
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic op_eni,
    input  logic op_disi,
    input  logic op_reti,
    output logic gie
);
    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.gie = 1'b0;
        end else if (op_disi) begin
            st_d.gie = 1'b0;
        end else if (op_eni || op_reti) begin
            st_d.gie = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= GATE_RESET;
        else        st_q <= st_d;
    end

    assign gie = st_q.gie;

    assert_entry_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gie);
    assert_disable_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_disi |=> !gie);
    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie) |-> $past(op_eni || op_reti));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !op_eni && !op_disi && !op_reti) |=> $stable(gie));
endmodule

// File: rtl/wake_decide.sv
module wake_decide (
    input  logic sleeping,
    input  logic any_live,
    input  logic gie,
    output logic wake_req,
    output logic wake_branch
);
    always_comb begin
        wake_req    = sleeping && any_live;
        wake_branch = wake_req && gie;
    end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
    parameter int NUM_SRC  = 8,
    parameter int VEC_W    = 10,
    parameter int VEC_ADDR = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_mask,
    input  logic               op_eni,
    input  logic               op_disi,
    input  logic               op_reti,
    input  logic               sleeping,
    input  logic               insn_end,
    output logic               gie,
    output logic               take_irq,
    output logic [VEC_W-1:0]   take_vec,
    output logic               wake_req,
    output logic               wake_branch
);
    localparam logic [VEC_W-1:0] VEC = VEC_W'(VEC_ADDR);

    logic any_live;
    logic take;

    irq_src_any #(.NUM_SRC(NUM_SRC)) u_any (
        .src_pend (src_pend),
        .src_mask (src_mask),
        .any_live (any_live)
    );

    gie_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .op_eni  (op_eni),
        .op_disi (op_disi),
        .op_reti (op_reti),
        .gie     (gie)
    );

    wake_decide u_wake (
        .sleeping    (sleeping),
        .any_live    (any_live),
        .gie         (gie),
        .wake_req    (wake_req),
        .wake_branch (wake_branch)
    );

    always_comb begin
        take     = gie && any_live && insn_end && !sleeping;
        take_irq = take;
        take_vec = take ? VEC : '0;
    end

    assert_vec_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (take_vec == VEC));
    assert_take_needs_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (gie && insn_end && !sleeping && |(src_pend & src_mask)));
    assert_branch_needs_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_branch |-> (wake_req && gie));
    assert_no_wake_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sleeping |-> !wake_req);
endmodule

// File: tb/irq_gate_ctrl_tb.sv
module irq_gate_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int N     = 3;
    localparam int VW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_pend = '0, src_mask = '0;
    logic          op_eni = 0, op_disi = 0, op_reti = 0, sleeping = 0, insn_end = 0;
    logic          gie, take_irq, wake_req, wake_branch;
    logic [VW-1:0] take_vec;

    int  errors = 0;
    int  checks = 0;
    bit  gie_m  = 0;
    bit  done   = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_gate_ctrl #(.NUM_SRC(N), .VEC_W(VW), .VEC_ADDR(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_mask(src_mask),
        .op_eni(op_eni), .op_disi(op_disi), .op_reti(op_reti),
        .sleeping(sleeping), .insn_end(insn_end), .gie(gie),
        .take_irq(take_irq), .take_vec(take_vec),
        .wake_req(wake_req), .wake_branch(wake_branch)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [N-1:0] f, input logic [N-1:0] e,
                        input logic b, input logic s,
                        input logic en, input logic di, input logic re);
        bit    any, t;
        string tag;
        @(negedge clk);
        src_pend = f; src_mask = e; insn_end = b; sleeping = s;
        op_eni = en; op_disi = di; op_reti = re;
        #1;
        any = |(f & e);
        t   = gie_m && any && b && !s;
        chk("R4", int'(take_irq), int'(t));
        chk("R6", int'(take_vec), t ? 1 : 0);
        chk("R7", int'(wake_req), int'(s && any));
        chk("R8", int'(wake_branch), int'(s && any && gie_m));
        if (t)             begin gie_m = 0; tag = "R5"; end
        else if (di)       begin gie_m = 0; tag = "R3"; end
        else if (en || re) begin gie_m = 1; tag = "R2"; end
        else               tag = "R9";
        @(posedge clk); #1;
        chk(tag, int'(gie), int'(gie_m));
    endtask

    task automatic set_gie(input bit g);
        if (g) step('0, '0, 0, 0, 1, 0, 0);
        else   step('0, '0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(gie), 0);
        chk("R1", int'(take_irq), 0);
        chk("R1", int'(wake_req), 0);
        chk("R1", int'(wake_branch), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", int'(gie), 0);

        // Sweep of sources, boundary and sleep against both flag states (R4, R6, R7, R8)
        for (int g = 0; g < 2; g++) begin
            for (int f = 0; f < (1 << N); f++) begin
                for (int e = 0; e < (1 << N); e++) begin
                    for (int b = 0; b < 2; b++) begin
                        for (int s = 0; s < 2; s++) begin
                            if (gie_m != g[0]) set_gie(g[0]);
                            step(N'(f), N'(e), b[0], s[0], 0, 0, 0);
                        end
                    end
                end
            end
        end

        // Strobe precedence with and without an entry in the same cycle (R2, R3, R5, R9)
        for (int g = 0; g < 2; g++) begin
            for (int k = 0; k < 8; k++) begin
                for (int live = 0; live < 2; live++) begin
                    set_gie(g[0]);
                    step(live[0] ? N'(1) : N'(0), N'(1), 1, 0, k[0], k[1], k[2]);
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule